// File: doc/BRIEF.md
# Shared-Buffer Per-Output Cell Queue Manager

This block manages one RAM that holds cells for every output port of a switch. Every output port has its own first-in first-out queue, and all of these queues live in the same storage. Each queue is a linked list. A pool of idle addresses supplies storage for each arriving cell. An array of link words chains the cells of one output together. Head and tail registers mark the two ends of every queue. The cell RAM is part of the block.

Each cycle the block can accept at most one cell on the write side. It reads the destination port and takes an address from the idle pool. It stores the cell at that address and appends the address to the tail of the chosen queue. If the pool is empty, the cell is discarded and counted. On the read side, a read request releases at most one cell. The block visits the non-empty queues in cyclic order and removes the head cell of the queue it picks. It then presents that cell together with its port number and returns the address to the idle pool in the same cycle.

Top module: `cellQueueMgr`

## Requirements
- R1: While `rstN` is low and in the first cycle after it goes high, `queueEmpty` is all ones, `rdValid` is 0 and `dropCount` is 0, and the idle pool holds all DEPTH addresses.
- R2: A write that is accepted on a clock edge makes `queueEmpty[wrDest]` read 0 after that edge.
- R3: The cells of any one output are read out in the order in which they were written.
- R4: When `rdEnable` is 1 on an edge and at least one queue is non-empty, `rdValid` is 1 after that edge and `rdData` carries the removed cell. Otherwise `rdValid` is 0 after that edge.
- R5: A read serves the first non-empty queue after the queue served last, counting upward in index and wrapping from NUM_PORTS-1 to 0. After reset the search starts at index 0. `rdPort` gives the index of the queue served.
- R6: Empty queues are skipped, so a read request never goes unserved while any queue holds a cell.
- R7: A read that removes the only cell of a queue makes that queue's `queueEmpty` bit read 1 after the edge, unless the same edge also writes to that queue.
- R8: A write that arrives while the idle pool is empty is discarded. The queues do not change, and `dropCount` rises by exactly one. The pool is empty exactly when DEPTH cells are held. This check uses the state before the edge, so a read on the same edge does not rescue the write.
- R9: A freed address is returned to the idle pool on the same edge, so after queues drain, later writes are accepted again up to the full DEPTH.
- R10: If a queue holds exactly one cell and the same edge reads that cell and appends a new cell to that queue, the old cell is delivered and the new cell stays queued.
- R11: `dropCount` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A cell is offered this cycle |
| wrDest | input | $clog2(NUM_PORTS) | Output port index of the offered cell |
| wrData | input | DATA_W | Cell payload |
| rdEnable | input | 1 | One read slot is available this cycle |
| rdValid | output | 1 | A cell was removed on the previous edge |
| rdPort | output | $clog2(NUM_PORTS) | Output port the removed cell belongs to |
| rdData | output | DATA_W | Payload of the removed cell |
| queueEmpty | output | NUM_PORTS | One bit per output, 1 when its queue holds no cell |
| dropCount | output | DROP_W | Saturating count of discarded writes |

## Verification
Every result is registered, so a stimulus applied before edge N shows up right after edge N. This holds for the delivered cell and its port, for the empty flags and for the drop count. The bench drives inputs on the falling edge. At the next falling edge, before it drives the next stimulus, it compares the outputs against a per-port queue model that it advanced when it drove the previous stimulus. The model applies the read first, using the queue occupancy before the edge, and then the write. This follows the same-edge rules of R8 and R10. The bench runs directed sweeps over every port and a long pseudo-random phase, then finishes with a saturation run of the drop counter.

// File: rtl/qmPkg.sv
package qmPkg;

  // Per-cycle strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic pushCell;   // store the offered cell and link it onto its queue
    logic popCell;    // unlink the head of the selected queue
    logic countDrop;  // offered cell is discarded for lack of space
  } qmStrobe_t;

endpackage

// File: rtl/qmCtrl.sv
module qmCtrl
  import qmPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [PORT_W-1:0]    wrDest,
  input  logic                 rdEnable,
  input  logic [NUM_PORTS-1:0] queueEmpty,
  input  logic                 freeEmpty,
  output qmStrobe_t            strobe,
  output logic [PORT_W-1:0]    pushQueue,
  output logic [PORT_W-1:0]    popQueue
);

  logic [PORT_W-1:0] lastServed;
  logic [PORT_W-1:0] pick;
  logic              anyReady;

  // Cyclic search starting one past the queue served last.
  always_comb begin
    int s;
    anyReady = 1'b0;
    pick     = lastServed;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      s = int'(lastServed) + k;
      if (s >= NUM_PORTS) s = s - NUM_PORTS;
      if (!anyReady && !queueEmpty[s]) begin
        anyReady = 1'b1;
        pick     = s[PORT_W-1:0];
      end
    end
  end

  always_comb begin
    strobe.popCell   = rdEnable & anyReady;
    strobe.pushCell  = wrValid & ~freeEmpty;
    strobe.countDrop = wrValid & freeEmpty;
    pushQueue        = wrDest;
    popQueue         = pick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastServed <= PORT_W'(NUM_PORTS - 1);
    end else if (strobe.popCell) begin
      lastServed <= pick;
    end
  end

endmodule

// File: rtl/qmDatapath.sv
module qmDatapath
  import qmPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 8,
  parameter int DROP_W    = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS),
  parameter int ADDR_W    = $clog2(DEPTH),
  parameter int CNT_W     = ADDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qmStrobe_t            strobe,
  input  logic [PORT_W-1:0]    pushQueue,
  input  logic [PORT_W-1:0]    popQueue,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 freeEmpty,
  output logic [NUM_PORTS-1:0] queueEmpty,
  output logic                 rdValid,
  output logic [PORT_W-1:0]    rdPort,
  output logic [DATA_W-1:0]    rdData,
  output logic [DROP_W-1:0]    dropCount
);

  // Storage: cell payloads and link words (no reset needed).
  logic [DATA_W-1:0] cellMem [DEPTH];
  logic [ADDR_W-1:0] nextPtr [DEPTH];

  // Idle-address pool as a circular buffer.
  logic [ADDR_W-1:0] freeList [DEPTH];
  logic [ADDR_W-1:0] freeRd, freeWr;
  logic [CNT_W-1:0]  freeCnt;

  // Per-output queue ends.
  logic [ADDR_W-1:0]    headPtr [NUM_PORTS];
  logic [ADDR_W-1:0]    tailPtr [NUM_PORTS];
  logic [NUM_PORTS-1:0] emptyQ;

  logic [ADDR_W-1:0] newAddr, oldHead;
  logic              lastCell, appendFresh;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_comb begin
    newAddr     = freeList[freeRd];
    oldHead     = headPtr[popQueue];
    lastCell    = (headPtr[popQueue] == tailPtr[popQueue]);
    appendFresh = emptyQ[pushQueue] |
                  (strobe.popCell & (popQueue == pushQueue) & lastCell);
    freeEmpty   = (freeCnt == '0);
  end

  // Payload and link storage.
  always_ff @(posedge clk) begin
    if (strobe.pushCell) begin
      cellMem[newAddr] <= wrData;
      if (!appendFresh) nextPtr[tailPtr[pushQueue]] <= newAddr;
    end
  end

  // Queue ends, idle pool, read register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) freeList[i] <= ADDR_W'(i);
      for (int p = 0; p < NUM_PORTS; p++) begin
        headPtr[p] <= '0;
        tailPtr[p] <= '0;
      end
      emptyQ  <= '1;
      freeRd  <= '0;
      freeWr  <= '0;
      freeCnt <= CNT_W'(DEPTH);
      rdValid <= 1'b0;
      rdPort  <= '0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.popCell;
      if (strobe.popCell) begin
        rdPort           <= popQueue;
        rdData           <= cellMem[oldHead];
        freeList[freeWr] <= oldHead;
        freeWr           <= bump(freeWr);
        if (lastCell) emptyQ[popQueue] <= 1'b1;
        else          headPtr[popQueue] <= nextPtr[oldHead];
      end
      if (strobe.pushCell) begin
        freeRd <= bump(freeRd);
        tailPtr[pushQueue] <= newAddr;
        if (appendFresh) begin
          headPtr[pushQueue] <= newAddr;
          emptyQ[pushQueue]  <= 1'b0;
        end
      end
      freeCnt <= freeCnt + CNT_W'(strobe.popCell) - CNT_W'(strobe.pushCell);
    end
  end

  // Saturating drop counter.
  always_ff @(posedge clk) begin
    if (!rstN)                                   dropCount <= '0;
    else if (strobe.countDrop && dropCount != '1) dropCount <= dropCount + 1'b1;
  end

  assign queueEmpty = emptyQ;

endmodule

// File: rtl/cellQueueMgr.sv
module cellQueueMgr
  import qmPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 8,
  parameter int DROP_W    = 8,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [PORT_W-1:0]    wrDest,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEnable,
  output logic                 rdValid,
  output logic [PORT_W-1:0]    rdPort,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_PORTS-1:0] queueEmpty,
  output logic [DROP_W-1:0]    dropCount
);

  qmStrobe_t         strobe;
  logic [PORT_W-1:0] pushQueue, popQueue;
  logic              freeEmpty;

  qmCtrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrDest(wrDest),
    .rdEnable(rdEnable), .queueEmpty(queueEmpty), .freeEmpty(freeEmpty),
    .strobe(strobe), .pushQueue(pushQueue), .popQueue(popQueue)
  );

  qmDatapath #(
    .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .DATA_W(DATA_W),
    .DROP_W(DROP_W), .PORT_W(PORT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushQueue(pushQueue),
    .popQueue(popQueue), .wrData(wrData), .freeEmpty(freeEmpty),
    .queueEmpty(queueEmpty), .rdValid(rdValid), .rdPort(rdPort),
    .rdData(rdData), .dropCount(dropCount)
  );

endmodule

// File: rtl/qmChecker.sv
module qmChecker #(
  parameter int NUM_PORTS = 4,
  parameter int DROP_W    = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrValid,
  input logic                 rdEnable,
  input logic                 rdValid,
  input logic [PORT_W-1:0]    rdPort,
  input logic [NUM_PORTS-1:0] queueEmpty,
  input logic [DROP_W-1:0]    dropCount
);

  logic [NUM_PORTS-1:0] emptyPrev;
  always_ff @(posedge clk) begin
    if (!rstN) emptyPrev <= '1;
    else       emptyPrev <= queueEmpty;
  end

  assert_read_needs_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEnable));

  assert_no_idle_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnable && (queueEmpty != '1)) |=> rdValid);

  assert_served_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !emptyPrev[rdPort]);

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dropCount == $past(dropCount)) || (dropCount == $past(dropCount) + 1'b1)));

  assert_drop_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> $past(wrValid));

endmodule

bind cellQueueMgr qmChecker #(.NUM_PORTS(NUM_PORTS), .DROP_W(DROP_W)) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdEnable(rdEnable),
  .rdValid(rdValid), .rdPort(rdPort), .queueEmpty(queueEmpty),
  .dropCount(dropCount)
);

// File: tb/sim_cellQueueMgr.sv
`timescale 1ns/1ps
module sim_cellQueueMgr;
  localparam int NP = 4;
  localparam int DEPTH = 8;
  localparam int DW = 8;
  localparam int DROPW = 8;
  localparam int DROPMAX = (1 << DROPW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, rdEnable = 1'b0;
  logic [1:0] wrDest = '0;
  logic [DW-1:0] wrData = '0;
  logic rdValid;
  logic [1:0] rdPort;
  logic [DW-1:0] rdData;
  logic [NP-1:0] queueEmpty;
  logic [DROPW-1:0] dropCount;

  always #10 clk = ~clk;

  cellQueueMgr #(.NUM_PORTS(NP), .DEPTH(DEPTH), .DATA_W(DW), .DROP_W(DROPW)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrDest(wrDest), .wrData(wrData),
    .rdEnable(rdEnable), .rdValid(rdValid), .rdPort(rdPort), .rdData(rdData),
    .queueEmpty(queueEmpty), .dropCount(dropCount)
  );

  int tests = 0, fails = 0;
  int mq [NP][DEPTH];
  int mHead [NP];
  int mCnt [NP];
  int mLast = NP - 1;
  int mDrop = 0;
  bit expValid = 0;
  int expPort = 0, expData = 0;
  bit finished = 0;

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expEmptyVec();
    int v = 0;
    for (int p = 0; p < NP; p++) if (mCnt[p] == 0) v |= (1 << p);
    return v;
  endfunction

  // Check outcome of previous cycle, then advance model and drive new stimulus.
  task automatic step(bit wv, int wd, int wdat, bit re);
    int total, s;
    bit found;
    @(negedge clk);
    check("R4 rdValid", int'(rdValid), int'(expValid));
    if (expValid) begin
      check("R5 rdPort", int'(rdPort), expPort);
      check("R3 R9 R10 rdData", int'(rdData), expData);
    end
    check("R2 R7 queueEmpty", int'(queueEmpty), expEmptyVec());
    check("R8 R11 dropCount", int'(dropCount), mDrop);
    total = 0;
    for (int p = 0; p < NP; p++) total += mCnt[p];
    found = 0;
    for (int k = 1; k <= NP; k++) begin
      s = (mLast + k) % NP;
      if (!found && mCnt[s] > 0) begin found = 1; expPort = s; end
    end
    expValid = re && found;  // R6: any non-empty queue is served
    if (expValid) begin
      expData = mq[expPort][mHead[expPort]];
      mHead[expPort] = (mHead[expPort] + 1) % DEPTH;
      mCnt[expPort]--;
      mLast = expPort;
    end
    if (wv) begin
      if (total == DEPTH) begin
        if (mDrop < DROPMAX) mDrop++;
      end else begin
        mq[wd][(mHead[wd] + mCnt[wd]) % DEPTH] = wdat & 8'hFF;
        mCnt[wd]++;
      end
    end
    wrValid = wv; wrDest = 2'(wd); wrData = DW'(wdat); rdEnable = re;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int lfsr;
    for (int p = 0; p < NP; p++) begin mHead[p] = 0; mCnt[p] = 0; end
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rdValid", int'(rdValid), 0);
    check("R1 queueEmpty", int'(queueEmpty), 4'hF);
    check("R1 dropCount", int'(dropCount), 0);
    rstN = 1'b1;

    // Fill every port with two cells, then one extra write is dropped (R8).
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < NP; p++) step(1, p, p * 16 + i, 0);
    step(1, 1, 8'hEE, 0);
    // Drain: cyclic order 0,1,2,3,0,1,2,3 (R5), FIFO order (R3), empties (R7)
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1);

    // R6: only ports 1 and 3 hold cells; empties are skipped
    step(1, 3, 8'h31, 0);
    step(1, 1, 8'h11, 0);
    step(1, 3, 8'h32, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);

    // R10: one-cell queue read and appended on the same edge
    step(1, 2, 8'hA1, 0);
    step(1, 2, 8'hA2, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);

    // R8: a read on the same edge does not rescue a write into a full buffer
    for (int i = 0; i < DEPTH; i++) step(1, i % NP, 8'h40 + i, 0);
    step(1, 0, 8'h77, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1);

    // R9: address reuse under mixed traffic
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 3000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      step(lfsr[3:0] < 4'd10, lfsr[5:4], lfsr[15:8], lfsr[19:16] < 4'd8);
    end
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1);

    // R11: saturation of the drop counter
    for (int i = 0; i < DEPTH + DROPMAX + 5; i++) step(1, i % NP, i, 0);
    step(0, 0, 0, 0);
    check("R11 saturated dropCount", int'(dropCount), DROPMAX);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule